// File: doc/BRIEF.md
# Radio Frame Buffer and Interrupt Controller

This block sits between an SPI-driven register port and the baseband of a packet radio. It keeps a transmit frame buffer that the host fills and the radio reads byte by byte, and a receive frame buffer that the radio fills and the host reads back. It also holds the small set of control, status and interrupt registers that sequence a transmission, report its result, announce received frames and keep the receive buffer stable while the host is reading it.

The host port is byte wide. A select bit picks between a 6-bit short register space and a 10-bit long space that holds both buffers. A read returns its data one clock after the enable. The radio side sees a start request that it acknowledges, a byte index into the transmit buffer, a done/fail result, and a byte stream for received frames with a last-byte marker and the quality and strength values. The interrupt output is active low.

The transmit sequencer has three states. TX_IDLE goes to TX_REQ on a host write with the start bit set. TX_REQ goes to TX_BUSY when the radio accepts. TX_BUSY goes back to TX_IDLE on the done pulse. The receive filler also has three states. RX_IDLE goes to RX_RECV on the first byte of a frame. If reception is inhibited at that moment, RX_IDLE goes to RX_DROP instead. A single-byte frame stays in RX_IDLE. Both RX_RECV and RX_DROP return to RX_IDLE on the last byte.

Top module: `radio_fbuf_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1 and `tx_req` is 0. The interrupt control register (short 0x32) reads 0x09, meaning both interrupts are masked. The interrupt status register (short 0x31), the transmit status register (short 0x24) and the transmit control register (short 0x1B) all read 0x00.
- R2: Long addresses 0x000 to 0x07F are the transmit buffer, writable and readable by the host. `tx_byte` shows the buffer byte selected by `tx_idx`.
- R3: Writing short 0x1B with bit 0 set while idle raises `tx_req` from the next cycle. `tx_ack_req` follows bit 2 of that write. Bit 0 of 0x1B reads 1 until the cycle in which `tx_accept` is seen, then reads 0 and `tx_req` falls.
- R4: A start write while a transmission is requested or in flight is ignored. `tx_req` stays low during flight, and the stored acknowledge bit keeps its value.
- R5: A `tx_done` pulse during flight sets interrupt status bit 0. It also loads transmit status bit 0 with `tx_fail`: 1 means the retries were exhausted, 0 means success.
- R6: A received frame of N bytes is stored at long 0x300 as follows. N is at offset 0, the frame bytes are at offsets 1 to N, the quality byte is at N+1 and the strength byte is at N+2. The last byte sets interrupt status bit 3.
- R7: A frame longer than 141 bytes keeps only its first 141 bytes. The length byte reads 141, and the trailer bytes go to offsets 142 and 143.
- R8: While bit 2 of short 0x39 is 1, a frame that starts is dropped completely. The receive buffer is unchanged and no status bit is set.
- R9: In short 0x32, bit 0 masks the transmit interrupt and bit 3 masks the receive interrupt, and a 1 masks. `irq_n` is 0 exactly when an unmasked status bit is set.
- R10: A read of short 0x31 returns the status and clears it. If a new event occurs in the same cycle as that read, the read returns the old value and the new bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_long | input | 1 | 1 = long space, 0 = short space (low 6 address bits) |
| reg_addr | input | 10 | Register or buffer address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after a read strobe |
| tx_req | output | 1 | Transmit start request, held until accepted |
| tx_ack_req | output | 1 | Frame asks for an acknowledgement |
| tx_accept | input | 1 | Radio accepts the start request |
| tx_idx | input | 7 | Transmit buffer byte index from the radio |
| tx_byte | output | 8 | Transmit buffer byte at `tx_idx` |
| tx_done | input | 1 | Transmission finished pulse |
| tx_fail | input | 1 | Result with `tx_done`: retries exhausted |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_lqi | input | 8 | Link quality, sampled with the last byte |
| rx_rssi | input | 8 | Signal strength, sampled with the last byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The clear-on-read of the interrupt status and the raising of a status bit can land on the same clock edge. The bench provokes this by issuing a read of short 0x31 in the very cycle that carries the `tx_done` pulse. It expects that read to return the earlier value, without bit 0. A second read must then return 0x01, which shows that the event survived the clear. The same collision is also covered by a clocked property inside the status logic.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
    localparam logic [5:0] SA_TXCON   = 6'h1B;
    localparam logic [5:0] SA_TXSTAT  = 6'h24;
    localparam logic [5:0] SA_INTSTAT = 6'h31;
    localparam logic [5:0] SA_INTCON  = 6'h32;
    localparam logic [5:0] SA_BBCTL   = 6'h39;
    localparam logic [9:0] LA_RXBUF   = 10'h300;

    typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_BUSY} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_RECV, RX_DROP} rx_state_t;
endpackage

// File: rtl/rfb_tx_seq.sv
module rfb_tx_seq
    import rfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_bit,
    input  logic ack_bit,
    input  logic tx_accept,
    input  logic tx_done,
    input  logic tx_fail,
    output logic tx_req,
    output logic ack_req,
    output logic pending,
    output logic fail_flag,
    output logic done_evt
);
    tx_state_t state_q, state_d;
    logic ack_q, fail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (start_wr && start_bit) state_d = TX_REQ;
            TX_REQ:  if (tx_accept)             state_d = TX_BUSY;
            TX_BUSY: if (tx_done)               state_d = TX_IDLE;
            default:                            state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (start_wr && state_q == TX_IDLE) ack_q <= ack_bit;
            if (state_q == TX_BUSY && tx_done)  fail_q <= tx_fail;
        end
    end

    always_comb begin
        tx_req    = (state_q == TX_REQ);
        pending   = (state_q == TX_REQ);
        ack_req   = ack_q;
        fail_flag = fail_q;
        done_evt  = (state_q == TX_BUSY) && tx_done;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_accept) |=> tx_req);
    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_accept) |=> !tx_req);
    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_BUSY && !tx_done) |=> !tx_req);
endmodule

// File: rtl/rfb_rx_fill.sv
module rfb_rx_fill
    import rfb_pkg::*;
#(
    parameter int DEPTH = 144,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inhibit,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rx_last,
    input  logic [7:0]    rx_lqi,
    input  logic [7:0]    rx_rssi,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          rx_evt
);
    localparam logic [IW-1:0] CAP   = IW'(DEPTH - 3);
    localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

    rx_state_t state_q, state_d;
    logic [IW-1:0] cnt_q, cnt_cur, n_new;
    logic [7:0] mem_q [DEPTH];
    logic take, room, finish;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (rx_valid && !rx_last) state_d = inhibit ? RX_DROP : RX_RECV;
            RX_RECV: if (rx_valid && rx_last)  state_d = RX_IDLE;
            RX_DROP: if (rx_valid && rx_last)  state_d = RX_IDLE;
            default:                           state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        take    = rx_valid && ((state_q == RX_IDLE && !inhibit) || state_q == RX_RECV);
        cnt_cur = (state_q == RX_IDLE) ? '0 : cnt_q;
        room    = cnt_cur < CAP;
        n_new   = room ? cnt_cur + 1'b1 : cnt_cur;
        finish  = take && rx_last;
        rx_evt  = finish;
        rd_data = (rd_idx < DEPTH_W) ? mem_q[rd_idx] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else begin
            if (take) cnt_q <= n_new;
            if (take && room) mem_q[cnt_cur + 1'b1] <= rx_byte;
            if (finish) begin
                mem_q[0]              <= 8'(n_new);
                mem_q[n_new + 1'b1]   <= rx_lqi;
                mem_q[n_new + 2'd2]   <= rx_rssi;
            end
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);
    // R8
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DROP) |-> !rx_evt);
endmodule

// File: rtl/rfb_irq.sv
module rfb_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_evt,
    input  logic       rx_evt,
    input  logic       clr_rd,
    input  logic       mask_wr,
    input  logic       mask_tx_in,
    input  logic       mask_rx_in,
    output logic [7:0] status,
    output logic [7:0] mask,
    output logic       irq_n
);
    logic tx_st_q, rx_st_q, tx_m_q, rx_m_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_st_q <= 1'b0;
            rx_st_q <= 1'b0;
            tx_m_q  <= 1'b1;
            rx_m_q  <= 1'b1;
        end else begin
            tx_st_q <= tx_evt | (tx_st_q & ~clr_rd);
            rx_st_q <= rx_evt | (rx_st_q & ~clr_rd);
            if (mask_wr) begin
                tx_m_q <= mask_tx_in;
                rx_m_q <= mask_rx_in;
            end
        end
    end

    always_comb begin
        status = {4'b0, rx_st_q, 2'b0, tx_st_q};
        mask   = {4'b0, rx_m_q, 2'b0, tx_m_q};
        irq_n  = !((tx_st_q && !tx_m_q) || (rx_st_q && !rx_m_q));
    end

    // R10
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt && clr_rd) |=> status[0]);
    // R10
    clear_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !tx_evt && !rx_evt) |=> (status == 8'h00));
    // R9
    tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt && !mask_wr && !tx_m_q) |=> !irq_n);
endmodule

// File: rtl/radio_fbuf_ctrl.sv
module radio_fbuf_ctrl
    import rfb_pkg::*;
#(
    parameter int TX_DEPTH = 128,
    parameter int RX_DEPTH = 144,
    localparam int TIW = $clog2(TX_DEPTH),
    localparam int RIW = $clog2(RX_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_en,
    input  logic           reg_we,
    input  logic           reg_long,
    input  logic [9:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    output logic           tx_req,
    output logic           tx_ack_req,
    input  logic           tx_accept,
    input  logic [TIW-1:0] tx_idx,
    output logic [7:0]     tx_byte,
    input  logic           tx_done,
    input  logic           tx_fail,
    input  logic           rx_valid,
    input  logic [7:0]     rx_byte,
    input  logic           rx_last,
    input  logic [7:0]     rx_lqi,
    input  logic [7:0]     rx_rssi,
    output logic           irq_n
);
    localparam logic [9:0] TX_END = 10'(TX_DEPTH);
    localparam logic [9:0] RX_LEN = 10'(RX_DEPTH);

    logic [7:0] txb_q [TX_DEPTH];
    logic [7:0] bb_q, rdata_q, rd_mux, rx_rd, status, mask;
    logic [9:0] rx_off;
    logic tx_hit, rx_hit, wr, rd;
    logic s_txcon, s_txstat, s_intstat, s_intcon, s_bbctl;
    logic pending, fail_flag, done_evt, rx_evt;

    always_comb begin
        wr        = reg_en && reg_we;
        rd        = reg_en && !reg_we;
        rx_off    = reg_addr - LA_RXBUF;
        tx_hit    = reg_long && (reg_addr < TX_END);
        rx_hit    = reg_long && (reg_addr >= LA_RXBUF) && (rx_off < RX_LEN);
        s_txcon   = !reg_long && reg_addr[5:0] == SA_TXCON;
        s_txstat  = !reg_long && reg_addr[5:0] == SA_TXSTAT;
        s_intstat = !reg_long && reg_addr[5:0] == SA_INTSTAT;
        s_intcon  = !reg_long && reg_addr[5:0] == SA_INTCON;
        s_bbctl   = !reg_long && reg_addr[5:0] == SA_BBCTL;
    end

    rfb_tx_seq u_tx (
        .clk(clk), .rst_n(rst_n),
        .start_wr(wr && s_txcon), .start_bit(reg_wdata[0]), .ack_bit(reg_wdata[2]),
        .tx_accept(tx_accept), .tx_done(tx_done), .tx_fail(tx_fail),
        .tx_req(tx_req), .ack_req(tx_ack_req), .pending(pending),
        .fail_flag(fail_flag), .done_evt(done_evt)
    );

    rfb_rx_fill #(.DEPTH(RX_DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .inhibit(bb_q[2]),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .rx_lqi(rx_lqi), .rx_rssi(rx_rssi),
        .rd_idx(rx_off[RIW-1:0]), .rd_data(rx_rd), .rx_evt(rx_evt)
    );

    rfb_irq u_irq (
        .clk(clk), .rst_n(rst_n), .tx_evt(done_evt), .rx_evt(rx_evt),
        .clr_rd(rd && s_intstat), .mask_wr(wr && s_intcon),
        .mask_tx_in(reg_wdata[0]), .mask_rx_in(reg_wdata[3]),
        .status(status), .mask(mask), .irq_n(irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bb_q <= 8'h00;
            for (int i = 0; i < TX_DEPTH; i++) txb_q[i] <= 8'h00;
        end else if (wr) begin
            if (tx_hit)  txb_q[reg_addr[TIW-1:0]] <= reg_wdata;
            if (s_bbctl) bb_q <= reg_wdata;
        end
    end

    always_comb begin
        rd_mux = 8'h00;
        if (tx_hit)         rd_mux = txb_q[reg_addr[TIW-1:0]];
        else if (rx_hit)    rd_mux = rx_rd;
        else if (s_txcon)   rd_mux = {5'b0, tx_ack_req, 1'b0, pending};
        else if (s_txstat)  rd_mux = {7'b0, fail_flag};
        else if (s_intstat) rd_mux = status;
        else if (s_intcon)  rd_mux = mask;
        else if (s_bbctl)   rd_mux = bb_q;
        tx_byte = txb_q[tx_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata_q <= 8'h00;
        else if (rd) rdata_q <= rd_mux;
    end
    assign reg_rdata = rdata_q;

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (status != 8'h00));
endmodule

// File: tb/radio_fbuf_ctrl_tb.sv
module radio_fbuf_ctrl_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_en = 0, reg_we = 0, reg_long = 0;
    logic [9:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic tx_req, tx_ack_req, tx_accept = 0, tx_done = 0, tx_fail = 0;
    logic [6:0] tx_idx = '0;
    logic [7:0] tx_byte;
    logic rx_valid = 0, rx_last = 0;
    logic [7:0] rx_byte = '0, rx_lqi = '0, rx_rssi = '0;
    logic irq_n;
    int checks = 0, failures = 0;
    logic [7:0] d;

    always #10 clk = ~clk;

    radio_fbuf_ctrl dut_i (.*);

    // Transmit buffer vectors: {address, data}; expected readback = data.
    localparam logic [17:0] VEC [8] = '{
        {10'h000, 8'h00}, {10'h001, 8'h05}, {10'h002, 8'hA5}, {10'h003, 8'h5A},
        {10'h010, 8'hFF}, {10'h040, 8'h3C}, {10'h07E, 8'h81}, {10'h07F, 8'h7E}};

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic lng, input logic [9:0] a, input logic [7:0] v);
        @(negedge clk); reg_en = 1; reg_we = 1; reg_long = lng; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(input logic lng, input logic [9:0] a, output logic [7:0] v);
        @(negedge clk); reg_en = 1; reg_we = 0; reg_long = lng; reg_addr = a;
        @(negedge clk); reg_en = 0; v = reg_rdata;
    endtask

    task automatic frame(input int n, input logic [7:0] base, input logic [7:0] q, input logic [7:0] s);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_valid = 1; rx_byte = base + 8'(i); rx_last = (i == n - 1);
            rx_lqi = q; rx_rssi = s;
        end
        @(negedge clk); rx_valid = 0; rx_last = 0;
    endtask

    task automatic pulse_accept();
        @(negedge clk); tx_accept = 1;
        @(negedge clk); tx_accept = 0;
    endtask

    task automatic pulse_done(input logic f);
        @(negedge clk); tx_done = 1; tx_fail = f;
        @(negedge clk); tx_done = 0; tx_fail = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 irq_n", 8'(irq_n), 8'h01);
        chk("R1 tx_req", 8'(tx_req), 8'h00);
        rd(0, 10'h032, d); chk("R1 intcon", d, 8'h09);
        rd(0, 10'h031, d); chk("R1 intstat", d, 8'h00);
        rd(0, 10'h024, d); chk("R1 txstat", d, 8'h00);
        rd(0, 10'h01B, d); chk("R1 txcon", d, 8'h00);

        // R2 vector table walk
        for (int i = 0; i < 8; i++) wr(1, VEC[i][17:8], VEC[i][7:0]);
        for (int i = 0; i < 8; i++) begin
            rd(1, VEC[i][17:8], d); chk("R2 readback", d, VEC[i][7:0]);
            tx_idx = VEC[i][14:8]; #1; chk("R2 tx_byte", tx_byte, VEC[i][7:0]);
        end

        // R3 start with ack request
        wr(0, 10'h01B, 8'h05);
        chk("R3 tx_req up", 8'(tx_req), 8'h01);
        chk("R3 ack_req", 8'(tx_ack_req), 8'h01);
        rd(0, 10'h01B, d); chk("R3 txcon pending", d, 8'h05);
        pulse_accept();
        chk("R3 tx_req down", 8'(tx_req), 8'h00);
        rd(0, 10'h01B, d); chk("R3 txcon self clear", d, 8'h04);

        // R4 start ignored during flight
        wr(0, 10'h01B, 8'h01);
        chk("R4 no new req", 8'(tx_req), 8'h00);
        chk("R4 ack kept", 8'(tx_ack_req), 8'h01);

        // R5 failure result, still masked (R9)
        pulse_done(1'b1);
        chk("R9 masked irq", 8'(irq_n), 8'h01);
        rd(0, 10'h024, d); chk("R5 txstat fail", d, 8'h01);
        rd(0, 10'h031, d); chk("R5 intstat tx", d, 8'h01);
        rd(0, 10'h031, d); chk("R10 cleared", d, 8'h00);

        // R9 unmask and successful transmission
        wr(0, 10'h032, 8'h00);
        wr(0, 10'h01B, 8'h01);
        chk("R3 ack cleared", 8'(tx_ack_req), 8'h00);
        pulse_accept();
        pulse_done(1'b0);
        chk("R9 irq low", 8'(irq_n), 8'h00);
        rd(0, 10'h024, d); chk("R5 txstat ok", d, 8'h00);
        rd(0, 10'h031, d); chk("R10 read value", d, 8'h01);
        chk("R9 irq released", 8'(irq_n), 8'h01);

        // R6 receive frame
        frame(5, 8'hA0, 8'h55, 8'h66);
        chk("R6 irq low", 8'(irq_n), 8'h00);
        rd(0, 10'h031, d); chk("R6 intstat rx", d, 8'h08);
        rd(1, 10'h300, d); chk("R6 length", d, 8'h05);
        for (int i = 1; i <= 5; i++) begin
            rd(1, 10'h300 + 10'(i), d); chk("R6 frame byte", d, 8'hA0 + 8'(i - 1));
        end
        rd(1, 10'h306, d); chk("R6 lqi", d, 8'h55);
        rd(1, 10'h307, d); chk("R6 rssi", d, 8'h66);

        // R9 receive masked
        wr(0, 10'h032, 8'h08);
        frame(2, 8'h10, 8'h01, 8'h02);
        chk("R9 rx masked", 8'(irq_n), 8'h01);
        rd(0, 10'h031, d); chk("R9 rx status", d, 8'h08);

        // R8 inhibit drops frame
        wr(0, 10'h039, 8'h04);
        frame(3, 8'hC0, 8'h77, 8'h88);
        rd(0, 10'h031, d); chk("R8 no status", d, 8'h00);
        rd(1, 10'h300, d); chk("R8 length kept", d, 8'h02);
        rd(1, 10'h301, d); chk("R8 byte kept", d, 8'h10);
        wr(0, 10'h039, 8'h00);

        // R7 truncation
        frame(150, 8'h00, 8'h9A, 8'hBC);
        rd(1, 10'h300, d); chk("R7 clamped len", d, 8'd141);
        rd(1, 10'h300 + 10'd141, d); chk("R7 last kept", d, 8'd140);
        rd(1, 10'h300 + 10'd142, d); chk("R7 lqi", d, 8'h9A);
        rd(1, 10'h300 + 10'd143, d); chk("R7 rssi", d, 8'hBC);
        rd(0, 10'h031, d); chk("R7 status", d, 8'h08);

        // R10 event in the same cycle as the clearing read
        wr(0, 10'h01B, 8'h01);
        pulse_accept();
        @(negedge clk); tx_done = 1; reg_en = 1; reg_we = 0; reg_long = 0; reg_addr = 10'h031;
        @(negedge clk); tx_done = 0; reg_en = 0; d = reg_rdata;
        chk("R10 same-cycle old value", d, 8'h00);
        rd(0, 10'h031, d); chk("R10 event kept", d, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule